// File: doc/BRIEF.md
# Three-Sample Majority Debounce Filter

This block cleans up a single noisy bit. On every clock where the sample strobe is high it takes one sample of the raw input and compares it with the clean level it currently presents. The clean level only changes once a run of consecutive samples has disagreed with it. Any sample that agrees with the level ends the run, and the count starts again from zero.

The state is the clean level (0 or 1) together with a run count of 0, 1 or 2, which gives six states. The clean level is driven straight from a flop, so a qualifying sample shows on the output one clock edge after it is taken.

Both the run length and the level after reset are parameters. Their defaults are three samples and a high level. A surrounding design supplies an input that is already synchronised and a strobe at whatever rate the debounce window needs.

Top module: `debounce_filter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the clean output is set to RESET_LEVEL (default 1) and the run count to 0, whatever `raw_in` and `sample_en` are.
- R2: When the third consecutive enabled sample differs from the clean output, the clean output takes the value of that sample.
- R3: One or two consecutive disagreeing enabled samples leave the clean output unchanged.
- R4: An enabled sample equal to the clean output clears the run count, so a flip afterwards needs a full new run of three disagreeing samples.
- R5: The run count never exceeds 2 (RUN_LEN-1). It returns to 0 on a flip, so a flip back needs three more disagreeing samples.
- R6: On a clock edge with `sample_en` low, the clean output and the run count both hold, and `raw_in` has no effect on them.
- R7: From reset, the input sequence 1 0 0 1 0 1 0 0 0 1 0 1 1 1, one sample per enabled edge, gives the outputs 1 1 1 1 1 1 1 1 0 0 0 0 0 1.
- R8: The clean output is registered. A flip shows right after the rising edge that takes the deciding sample, and not before that edge.
- R9: With RUN_LEN=5 and RESET_LEVEL=0, reset gives 0, four disagreeing samples keep 0, and the fifth one gives 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_en | input | 1 | High on cycles where `raw_in` is taken as a sample |
| raw_in | input | 1 | Noisy input bit, already synchronised |
| clean_out | output | 1 | Debounced level, driven from a flop |

## Verification
The bench has two instances. The main one uses the defaults: a run length of three and a high level after reset. That instance covers the reference sequence, runs that stop at two samples, runs broken by an agreeing sample, and strobe-gated samples. A second instance is built with a run length of five and a low level after reset. It shows that the count width, the terminal count and the reset level all follow the parameters, including a run that just falls short of a flip.

// File: rtl/dbn_pkg.sv
// Package: shared types for the debounce filter.
// It gives the action that the classifier decides for each clock and the rule
// that sizes the run counter.
package dbn_pkg;

    // What happens to the state on one clock edge
    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,  // strobe low: nothing changes
        ACT_CLEAR   = 2'd1,  // sample agrees: run count back to zero
        ACT_ADVANCE = 2'd2,  // sample disagrees, run not complete: count up
        ACT_FLIP    = 2'd3   // sample completes the run: take new level
    } dbn_act_e;

    // Counter width able to hold the values 0 .. run_len-1
    function automatic int run_width(input int run_len);
        return (run_len <= 2) ? 1 : $clog2(run_len);
    endfunction

endpackage

// File: rtl/dbn_classify.sv
// Module: dbn_classify
// Decides the action for this clock from the strobe, the raw sample, the
// present clean level and the run count.
// Assumes: the run count is always below RUN_LEN (the counter keeps it there).
module dbn_classify
    import dbn_pkg::*;
#(
    parameter int RUN_LEN = 3,
    localparam int CW     = run_width(RUN_LEN)
)(
    input  logic          sample_en,
    input  logic          raw,
    input  logic          level,
    input  logic [CW-1:0] run_cnt,
    output dbn_act_e      act
);

    localparam logic [CW-1:0] LAST = CW'(RUN_LEN - 1);

    // Pick one action per clock from the strobe and the comparison
    always_comb begin
        if (!sample_en)
            act = ACT_HOLD;
        else if (raw == level)
            act = ACT_CLEAR;
        else if (run_cnt == LAST)
            act = ACT_FLIP;
        else
            act = ACT_ADVANCE;
    end

endmodule

// File: rtl/dbn_streak.sv
// Module: dbn_streak
// Counts the enabled samples in a row that disagree with the clean level.
// Assumes: the action comes from dbn_classify. Reset is synchronous and active low.
module dbn_streak
    import dbn_pkg::*;
#(
    parameter int RUN_LEN = 3,
    localparam int CW     = run_width(RUN_LEN)
)(
    input  logic          clk,
    input  logic          rst_n,
    input  dbn_act_e      act,
    output logic [CW-1:0] run_cnt
);

    // Update the run count according to the action
    always_ff @(posedge clk) begin
        if (!rst_n)
            run_cnt <= '0;
        else begin
            case (act)
                ACT_CLEAR, ACT_FLIP: run_cnt <= '0;
                ACT_ADVANCE:         run_cnt <= run_cnt + 1'b1;
                default:             run_cnt <= run_cnt;
            endcase
        end
    end

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_cnt <= CW'(RUN_LEN - 1));

    // R4
    agree_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act == ACT_CLEAR) |=> (run_cnt == '0));

endmodule

// File: rtl/dbn_level.sv
// Module: dbn_level
// Holds the clean output level. It takes the raw sample only on a flip action.
// Assumes: reset is synchronous and active low, and RESET_LEVEL is the level after reset.
module dbn_level
    import dbn_pkg::*;
#(
    parameter logic RESET_LEVEL = 1'b1
)(
    input  logic     clk,
    input  logic     rst_n,
    input  dbn_act_e act,
    input  logic     raw,
    output logic     level
);

    // Register the clean level and load it on a completed run
    always_ff @(posedge clk) begin
        if (!rst_n)
            level <= RESET_LEVEL;
        else if (act == ACT_FLIP)
            level <= raw;
    end

    // R1
    reset_level_chk: assert property (@(posedge clk)
        !rst_n |=> (level == RESET_LEVEL));

endmodule

// File: rtl/debounce_filter.sv
// Module: debounce_filter (top)
// Filters one input bit. The registered clean level flips only after RUN_LEN
// consecutive enabled samples have disagreed with it.
// Assumes: raw_in is synchronous to clk, RUN_LEN >= 2, and rst_n is
// synchronous and active low.
module debounce_filter
    import dbn_pkg::*;
#(
    parameter int   RUN_LEN     = 3,
    parameter logic RESET_LEVEL = 1'b1
)(
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic raw_in,
    output logic clean_out
);

    localparam int CW = run_width(RUN_LEN);

    dbn_act_e      act;
    logic [CW-1:0] run_cnt;
    logic          level;

    dbn_classify #(.RUN_LEN(RUN_LEN)) u_classify (
        .sample_en (sample_en),
        .raw       (raw_in),
        .level     (level),
        .run_cnt   (run_cnt),
        .act       (act)
    );

    dbn_streak #(.RUN_LEN(RUN_LEN)) u_streak (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .run_cnt (run_cnt)
    );

    dbn_level #(.RESET_LEVEL(RESET_LEVEL)) u_level (
        .clk   (clk),
        .rst_n (rst_n),
        .act   (act),
        .raw   (raw_in),
        .level (level)
    );

    assign clean_out = level;

    // R2
    flip_only_on_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (level != $past(level))) |->
            $past(sample_en && (raw_in != level) && (run_cnt == CW'(RUN_LEN - 1))));

    // R6
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_en |=> ($stable(level) && $stable(run_cnt)));

endmodule

// File: tb/debounce_filter_test.sv
// Directed bench for debounce_filter: one task per scenario, and each task
// checks its own results.
module debounce_filter_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 1'b0, din_a = 1'b0, out_a;
    logic en_b = 1'b0, din_b = 1'b0, out_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;  // 50 MHz

    debounce_filter uut (
        .clk(clk), .rst_n(rst_n), .sample_en(en_a), .raw_in(din_a), .clean_out(out_a)
    );

    debounce_filter #(.RUN_LEN(5), .RESET_LEVEL(1'b0)) uut_long (
        .clk(clk), .rst_n(rst_n), .sample_en(en_b), .raw_in(din_b), .clean_out(out_b)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // drive at the falling edge, then sample 5 ns after the rising edge
    task automatic step_a(input logic d, input logic en);
        @(negedge clk); din_a = d; en_a = en;
        @(posedge clk); #5;
    endtask

    task automatic step_b(input logic d, input logic en);
        @(negedge clk); din_b = d; en_b = en;
        @(posedge clk); #5;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; en_a = 1'b1; din_a = 1'b0; en_b = 1'b1; din_b = 1'b1;
        repeat (2) @(posedge clk);
        #5;
        check("R1 reset level a", out_a, 1'b1);
        check("R9 reset level b", out_b, 1'b0);
        @(negedge clk); rst_n = 1'b1; en_a = 1'b0; en_b = 1'b0;
    endtask

    task automatic test_reference();
        logic [13:0] ins  = 14'b1001010001_0111;
        logic [13:0] outs = 14'b1111111100_0001;
        do_reset();
        for (int i = 13; i >= 0; i--) begin
            step_a(ins[i], 1'b1);
            check("R7 reference sequence", out_a, outs[i]);
        end
    endtask

    task automatic test_short_runs();
        do_reset();
        step_a(1'b0, 1'b1); check("R3 one disagree", out_a, 1'b1);
        step_a(1'b0, 1'b1); check("R3 two disagree", out_a, 1'b1);
        step_a(1'b1, 1'b1); check("R4 agree", out_a, 1'b1);
        step_a(1'b0, 1'b1);
        step_a(1'b0, 1'b1); check("R4 two after clear", out_a, 1'b1);
        step_a(1'b0, 1'b1); check("R2 third flips", out_a, 1'b0);
    endtask

    task automatic test_latency();
        do_reset();
        step_a(1'b0, 1'b1);
        step_a(1'b0, 1'b1);
        @(negedge clk); din_a = 1'b0; en_a = 1'b1;
        #5; check("R8 not before edge", out_a, 1'b1);
        @(posedge clk); #1;
        check("R8 right after edge", out_a, 1'b0);
    endtask

    task automatic test_after_flip();
        // out_a is 0 after test_latency and the run count is back to 0
        step_a(1'b1, 1'b1); check("R5 one back", out_a, 1'b0);
        step_a(1'b1, 1'b1); check("R5 two back", out_a, 1'b0);
        step_a(1'b1, 1'b1); check("R5 third back flips", out_a, 1'b1);
    endtask

    task automatic test_gating();
        do_reset();
        step_a(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) step_a(1'b0, 1'b0);
        check("R6 gated samples ignored", out_a, 1'b1);
        step_a(1'b0, 1'b1); check("R6 count held at two", out_a, 1'b1);
        step_a(1'b0, 1'b1); check("R6 run completes", out_a, 1'b0);
    endtask

    task automatic test_long_run();
        do_reset();
        for (int i = 0; i < 4; i++) step_b(1'b1, 1'b1);
        check("R9 four of five", out_b, 1'b0);
        step_b(1'b1, 1'b1);
        check("R9 fifth flips", out_b, 1'b1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog: got timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        test_reference();
        test_short_runs();
        test_latency();
        test_after_flip();
        test_gating();
        test_long_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule